// File: doc/BRIEF.md
# Floating-Point Compare Predicate Unit

This block compares two IEEE-754 operands of the same precision and reduces the pair to one of four relations: less, equal, greater or unordered. A three-bit condition code then picks one of eight predicates over that relation. On a cycle where the compare strobe is high, the one-bit predicate result is registered as the condition flag and is also written into a fixed bit of a 32-bit floating-point status word. The other bits of the status word's top nibble are cleared. A precision select chooses between single precision, which is carried in the low 32 bits of each 64-bit operand bus, and double precision, which uses the whole bus.

The comparison is quiet. Any NaN operand gives the unordered relation and never stops the compare. A signaling NaN also raises a one-cycle invalid-operation pulse. Arithmetic, rounding and exception trapping are handled elsewhere. A control unit drives the operands and the condition code, pulses the strobe, and reads the flag or the status word in the following cycle.

Top module: `fp_cmp_pred_unit`

## Requirements
- R1: An operand whose exponent field is all ones and whose fraction is nonzero is a NaN. If either operand is a NaN, the relation is unordered.
- R2: Condition codes select the predicate as follows. 1: unordered. 2: equal. 3: unordered or equal. 4: ordered less-than. 5: unordered or less-than. 6: ordered less-or-equal.
- R3: Condition code 0 always gives a false result. Each strobed compare replaces the previous flag, so a flag left at 1 by an earlier compare reads 0 after a compare that fails.
- R4: Condition code 7 gives a true result for every relation except strictly greater-than.
- R5: After a strobed compare, status bit 29 equals the condition flag, and bits 31, 30 and 28 read 0. Bits 27 down to 0 keep their previous values, so they stay 0 after reset.
- R6: Only bits [2:0] of the 4-bit condition input select the predicate. Bit 3 has no effect on the result.
- R7: Positive zero and negative zero compare equal. Ordered values follow sign-magnitude order: a negative operand is less than a positive one, and when both operands are negative the larger magnitude is the smaller value.
- R8: A strobed compare with at least one signaling NaN operand (quiet bit, the fraction MSB, equal to 0) sets the invalid-operation output high for exactly the next cycle. A compare that has only quiet NaN operands, and any cycle with no strobe, leaves that output low.
- R9: Reset sets the flag, the status word and the invalid pulse to 0. The flag and the status word change only in the cycle after a strobed compare, and they hold their values while the strobe is low.
- R10: When the precision select is 0, each operand is single precision in bits [31:0] (sign 31, exponent 30:23, fraction 22:0), and bits [63:32] are ignored. When it is 1, each operand is double precision (sign 63, exponent 62:52, fraction 51:0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| opa_i | input | 64 | First operand |
| opb_i | input | 64 | Second operand |
| dbl_i | input | 1 | Precision select: 1 selects double precision, 0 selects single precision |
| cond_i | input | 4 | Condition code. Only bits [2:0] are used |
| cmp_vld_i | input | 1 | Compare strobe |
| cflag_o | output | 1 | Registered condition flag |
| stat_o | output | 32 | Floating-point status word |
| inv_pulse_o | output | 1 | Invalid-operation pulse, raised for a signaling NaN operand |

## Verification
The predicate flag update and the invalid-operation pulse can fall in the same cycle. A strobed compare with a signaling-NaN operand under any condition code that includes unordered sets both the flag and the pulse after the same edge. The table-driven loop provokes this by running signaling-NaN operand pairs through all eight codes. Each sample is judged on the flag, status bit 29, the cleared top bits and the pulse together. A directed test then holds signaling-NaN operands on the bus with the strobe low, and confirms that neither the pulse nor the stored flag moves.

// File: rtl/fpcp_pkg.sv
package fpcp_pkg;

  typedef enum logic [1:0] {
    REL_LT = 2'd0,
    REL_EQ = 2'd1,
    REL_GT = 2'd2,
    REL_UN = 2'd3
  } fpcp_rel_e;

  typedef struct packed {
    logic sign;
    logic nan;
    logic snan;
    logic zero;
  } fpcp_flags_t;

  // Relation of two classified operands; magnitudes exclude the sign bit.
  function automatic fpcp_rel_e fpcp_order(input fpcp_flags_t fa, input fpcp_flags_t fb,
                                           input logic mag_lt, input logic mag_eq);
    fpcp_rel_e r;
    if (fa.nan || fb.nan)          r = REL_UN;
    else if (fa.zero && fb.zero)   r = REL_EQ;
    else if (fa.sign != fb.sign)   r = fa.sign ? REL_LT : REL_GT;
    else if (mag_eq)               r = REL_EQ;
    else if (fa.sign)              r = mag_lt ? REL_GT : REL_LT;
    else                           r = mag_lt ? REL_LT : REL_GT;
    return r;
  endfunction

  // Each code bit enables one relation: bit0 unordered, bit1 equal, bit2 less.
  function automatic logic fpcp_pred(input fpcp_rel_e rel, input logic [2:0] code);
    return (code[0] && rel == REL_UN) ||
           (code[1] && rel == REL_EQ) ||
           (code[2] && rel == REL_LT);
  endfunction

endpackage

// File: rtl/fpcp_opnd_class.sv
module fpcp_opnd_class
  import fpcp_pkg::*;
#(
  parameter int OPND_W = 64,
  parameter int SGL_W  = 32,
  parameter int DEXP_W = 11,
  parameter int SEXP_W = 8
) (
  input  logic [OPND_W-1:0] opnd_i,
  input  logic              dbl_i,
  output fpcp_flags_t       flags_o,
  output logic [OPND_W-2:0] mag_o
);
  localparam int DFRAC_W = OPND_W - 1 - DEXP_W;
  localparam int SFRAC_W = SGL_W - 1 - SEXP_W;
  localparam int PAD_W   = OPND_W - SGL_W;

  logic [DEXP_W-1:0]  d_exp;
  logic [DFRAC_W-1:0] d_frac;
  logic [SEXP_W-1:0]  s_exp;
  logic [SFRAC_W-1:0] s_frac;
  logic               exp_ones;
  logic               frac_nz;
  logic               quiet_bit;

  assign d_exp  = opnd_i[OPND_W-2 -: DEXP_W];
  assign d_frac = opnd_i[DFRAC_W-1:0];
  assign s_exp  = opnd_i[SGL_W-2 -: SEXP_W];
  assign s_frac = opnd_i[SFRAC_W-1:0];

  always_comb begin
    if (dbl_i) begin
      flags_o.sign = opnd_i[OPND_W-1];
      exp_ones     = &d_exp;
      frac_nz      = |d_frac;
      quiet_bit    = d_frac[DFRAC_W-1];
      mag_o        = opnd_i[OPND_W-2:0];
    end else begin
      flags_o.sign = opnd_i[SGL_W-1];
      exp_ones     = &s_exp;
      frac_nz      = |s_frac;
      quiet_bit    = s_frac[SFRAC_W-1];
      mag_o        = {{PAD_W{1'b0}}, opnd_i[SGL_W-2:0]};
    end
    flags_o.nan  = exp_ones && frac_nz;
    flags_o.snan = exp_ones && frac_nz && !quiet_bit;
    flags_o.zero = (mag_o == '0);
  end

endmodule

// File: rtl/fpcp_rel_unit.sv
module fpcp_rel_unit
  import fpcp_pkg::*;
#(
  parameter int MAG_W = 63
) (
  input  fpcp_flags_t      fa_i,
  input  fpcp_flags_t      fb_i,
  input  logic [MAG_W-1:0] mag_a_i,
  input  logic [MAG_W-1:0] mag_b_i,
  output fpcp_rel_e        rel_o,
  output logic             snan_any_o
);
  logic mag_lt;
  logic mag_eq;

  assign mag_lt     = (mag_a_i < mag_b_i);
  assign mag_eq     = (mag_a_i == mag_b_i);
  assign rel_o      = fpcp_order(fa_i, fb_i, mag_lt, mag_eq);
  assign snan_any_o = fa_i.snan || fb_i.snan;

endmodule

// File: rtl/fpcp_pred_eval.sv
module fpcp_pred_eval
  import fpcp_pkg::*;
#(
  parameter int COND_W = 4,
  parameter int CODE_W = 3
) (
  input  fpcp_rel_e         rel_i,
  input  logic [COND_W-1:0] cond_i,
  output logic [CODE_W-1:0] code_o,
  output logic              hit_o
);
  logic unused_cond_hi;

  assign code_o         = cond_i[CODE_W-1:0];
  assign unused_cond_hi = ^cond_i[COND_W-1:CODE_W];
  assign hit_o          = fpcp_pred(rel_i, code_o);

endmodule

// File: rtl/fp_cmp_pred_unit.sv
module fp_cmp_pred_unit
  import fpcp_pkg::*;
#(
  parameter int OPND_W   = 64,
  parameter int SGL_W    = 32,
  parameter int DEXP_W   = 11,
  parameter int SEXP_W   = 8,
  parameter int COND_W   = 4,
  parameter int STAT_W   = 32,
  parameter int FLAG_BIT = 29
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OPND_W-1:0] opa_i,
  input  logic [OPND_W-1:0] opb_i,
  input  logic              dbl_i,
  input  logic [COND_W-1:0] cond_i,
  input  logic              cmp_vld_i,
  output logic              cflag_o,
  output logic [STAT_W-1:0] stat_o,
  output logic              inv_pulse_o
);
  localparam int MAG_W  = OPND_W - 1;
  localparam int CODE_W = 3;
  localparam int NIB_LO = STAT_W - 4;
  localparam int N_OPND = 2;

  logic [N_OPND-1:0][OPND_W-1:0] opnd_arr;
  fpcp_flags_t                   flags_arr [N_OPND];
  logic [MAG_W-1:0]              mag_arr   [N_OPND];

  fpcp_rel_e         rel_w;
  logic              snan_any_w;
  logic              pred_hit_w;
  logic [CODE_W-1:0] code_w;
  logic [3:0]        nib_next_w;

  logic              cflag_q;
  logic [STAT_W-1:0] stat_q;
  logic              inv_q;

  assign opnd_arr[0] = opa_i;
  assign opnd_arr[1] = opb_i;

  for (genvar g = 0; g < N_OPND; g++) begin : g_class
    fpcp_opnd_class #(
      .OPND_W(OPND_W), .SGL_W(SGL_W), .DEXP_W(DEXP_W), .SEXP_W(SEXP_W)
    ) class_i (
      .opnd_i (opnd_arr[g]),
      .dbl_i  (dbl_i),
      .flags_o(flags_arr[g]),
      .mag_o  (mag_arr[g])
    );
  end

  fpcp_rel_unit #(.MAG_W(MAG_W)) rel_i (
    .fa_i      (flags_arr[0]),
    .fb_i      (flags_arr[1]),
    .mag_a_i   (mag_arr[0]),
    .mag_b_i   (mag_arr[1]),
    .rel_o     (rel_w),
    .snan_any_o(snan_any_w)
  );

  fpcp_pred_eval #(.COND_W(COND_W), .CODE_W(CODE_W)) pred_i (
    .rel_i (rel_w),
    .cond_i(cond_i),
    .code_o(code_w),
    .hit_o (pred_hit_w)
  );

  // Top nibble: the flag bit takes the result, the rest is cleared.
  always_comb begin
    for (int i = 0; i < 4; i++) begin
      nib_next_w[i] = ((NIB_LO + i) == FLAG_BIT) ? pred_hit_w : 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cflag_q <= 1'b0;
      stat_q  <= '0;
      inv_q   <= 1'b0;
    end else if (cmp_vld_i) begin
      cflag_q               <= pred_hit_w;
      stat_q[STAT_W-1:NIB_LO] <= nib_next_w;
      inv_q                 <= snan_any_w;
    end else begin
      inv_q <= 1'b0;
    end
  end

  assign cflag_o     = cflag_q;
  assign stat_o      = stat_q;
  assign inv_pulse_o = inv_q;

endmodule

// File: rtl/fpcp_checker.sv
module fpcp_checker #(
  parameter int STAT_W   = 32,
  parameter int FLAG_BIT = 29
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmp_vld_i,
  input logic [2:0]        code_i,
  input logic [1:0]        rel_i,
  input logic              snan_any_i,
  input logic              cflag_o,
  input logic [STAT_W-1:0] stat_o,
  input logic              inv_pulse_o
);
  localparam logic [1:0] C_GT = 2'd2;
  localparam logic [1:0] C_UN = 2'd3;

  p_flag_mirror_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stat_o[FLAG_BIT] == cflag_o);

  p_top_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_vld_i |=> (stat_o[31:30] == 2'b00) && !stat_o[28]);

  p_low_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_vld_i |=> stat_o[27:0] == $past(stat_o[27:0]));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_vld_i |=> $stable(stat_o) && $stable(cflag_o));

  p_never_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_vld_i && code_i == 3'd0) |=> !cflag_o);

  p_gt_false_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_vld_i && rel_i == C_GT) |=> !cflag_o);

  p_un_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_vld_i && rel_i == C_UN && code_i[0]) |=> cflag_o);

  p_inv_raise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_vld_i && snan_any_i) |=> inv_pulse_o);

  p_inv_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_vld_i |=> !inv_pulse_o);

endmodule

bind fp_cmp_pred_unit fpcp_checker #(.STAT_W(STAT_W), .FLAG_BIT(FLAG_BIT)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmp_vld_i  (cmp_vld_i),
  .code_i     (code_w),
  .rel_i      (rel_w),
  .snan_any_i (snan_any_w),
  .cflag_o    (cflag_o),
  .stat_o     (stat_o),
  .inv_pulse_o(inv_pulse_o)
);

// File: tb/fp_cmp_pred_unit_tb_top.sv
`timescale 1ns/1ps
module fp_cmp_pred_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] opa = '0;
  logic [63:0] opb = '0;
  logic        dbl = 1'b0;
  logic [3:0]  cond = '0;
  logic        vld = 1'b0;
  logic        cflag;
  logic [31:0] stat;
  logic        inv;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  fp_cmp_pred_unit dut_i (
    .clk(clk), .rst_n(rst_n), .opa_i(opa), .opb_i(opb), .dbl_i(dbl),
    .cond_i(cond), .cmp_vld_i(vld), .cflag_o(cflag), .stat_o(stat),
    .inv_pulse_o(inv)
  );

  // Bench relation codes: 0 less, 1 equal, 2 greater, 3 unordered.
  typedef struct packed {
    logic        dp;
    logic [63:0] a;
    logic [63:0] b;
    logic [1:0]  rel;
    logic        sn;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 64'h3F800000, 64'h40000000, 2'd0, 1'b0},              // R10 1<2
    '{1'b0, 64'h40000000, 64'h3F800000, 2'd2, 1'b0},
    '{1'b0, 64'hBF800000, 64'hC0000000, 2'd2, 1'b0},              // R7 -1>-2
    '{1'b0, 64'hC0000000, 64'hBF800000, 2'd0, 1'b0},              // R7
    '{1'b0, 64'h00000000, 64'h80000000, 2'd1, 1'b0},              // R7 +0==-0
    '{1'b0, 64'h7FC00000, 64'h3F800000, 2'd3, 1'b0},              // R1 qNaN
    '{1'b0, 64'h3F800000, 64'h7F800001, 2'd3, 1'b1},              // R8 sNaN
    '{1'b0, 64'hBF800000, 64'h3F800000, 2'd0, 1'b0},              // R7 signs
    '{1'b0, 64'hDEADBEEF3F800000, 64'h012345673F800000, 2'd1, 1'b0}, // R10 upper ignored
    '{1'b1, 64'h3FF0000000000000, 64'h4000000000000000, 2'd0, 1'b0},
    '{1'b1, 64'hBFF0000000000000, 64'hC000000000000000, 2'd2, 1'b0},
    '{1'b1, 64'h7FF8000000000000, 64'h3FF0000000000000, 2'd3, 1'b0}, // R1
    '{1'b1, 64'h7FF0000000000001, 64'h7FF0000000000001, 2'd3, 1'b1}, // R8
    '{1'b1, 64'h8000000000000000, 64'h0000000000000000, 2'd1, 1'b0},
    '{1'b1, 64'h7FF0000000000000, 64'h4000000000000000, 2'd2, 1'b0}, // inf
    '{1'b0, 64'hFF800000, 64'hC0000000, 2'd0, 1'b0},              // -inf
    '{1'b1, 64'h3FF0000000000001, 64'h3FF0000000000000, 2'd2, 1'b0}  // R10 low fraction bit
  };

  function automatic logic exp_pred(input logic [1:0] rel, input int code);
    case (code)
      0: return 1'b0;
      1: return rel == 2'd3;
      2: return rel == 2'd1;
      3: return rel == 2'd3 || rel == 2'd1;
      4: return rel == 2'd0;
      5: return rel == 2'd3 || rel == 2'd0;
      6: return rel == 2'd0 || rel == 2'd1;
      default: return rel != 2'd2;
    endcase
  endfunction

  task automatic check(input logic ok, input string tag, input logic [63:0] act,
                       input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic do_cmp(input logic dp, input logic [63:0] a, input logic [63:0] b,
                        input logic [3:0] c);
    @(negedge clk);
    dbl = dp; opa = a; opb = b; cond = c; vld = 1'b1;
    @(negedge clk);
    vld = 1'b0;
  endtask

  task automatic check_out(input logic ef, input logic ei, input string tag);
    logic [31:0] es;
    es = {2'b00, ef, 1'b0, 28'h0};
    check(cflag == ef, {tag, " flag"}, 64'(cflag), 64'(ef));
    check(stat == es, {tag, " R5 status"}, 64'(stat), 64'(es));
    check(inv == ei, {tag, " R8 pulse"}, 64'(inv), 64'(ei));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check(cflag == 1'b0, "R9 reset flag", 64'(cflag), 64'd0);
    check(stat == 32'h0, "R9 reset status", 64'(stat), 64'd0);
    check(inv == 1'b0, "R9 reset pulse", 64'(inv), 64'd0);
    rst_n = 1'b1;

    // Table walk over all eight codes; bit 3 toggled (R6).
    for (int v = 0; v < NV; v++) begin
      for (int c = 0; c < 8; c++) begin
        logic ef;
        ef = exp_pred(VEC[v].rel, c);
        do_cmp(VEC[v].dp, VEC[v].a, VEC[v].b, {1'(v + c), 3'(c)});
        check_out(ef, VEC[v].sn, (c == 7) ? "R4 vec" : (c == 0 ? "R3 vec" : "R2 R1 vec"));
      end
    end

    // R3: a failing compare clears a flag left at 1.
    do_cmp(1'b0, 64'h3F800000, 64'h3F800000, 4'd2);
    check_out(1'b1, 1'b0, "R3 set");
    do_cmp(1'b0, 64'h3F800000, 64'h3F800000, 4'd4);
    check_out(1'b0, 1'b0, "R3 clear");

    // R6: bit 3 alone on code 0, and with code 2.
    do_cmp(1'b0, 64'h3F800000, 64'h3F800000, 4'b1000);
    check_out(1'b0, 1'b0, "R6 hi code0");
    do_cmp(1'b0, 64'h3F800000, 64'h3F800000, 4'b1010);
    check_out(1'b1, 1'b0, "R6 hi code2");

    // R9/R8: no strobe, sNaN on bus, code 0: nothing moves.
    @(negedge clk);
    dbl = 1'b0; opa = 64'h7F800001; opb = 64'h3F800000; cond = 4'd0; vld = 1'b0;
    repeat (3) @(negedge clk);
    check_out(1'b1, 1'b0, "R9 hold");

    // R8: pulse lasts one cycle only.
    do_cmp(1'b0, 64'h7F800001, 64'h3F800000, 4'd1);
    check_out(1'b1, 1'b1, "R8 snan");
    @(negedge clk);
    check(inv == 1'b0, "R8 pulse width", 64'(inv), 64'd0);

    // R9: reset in mid-run clears everything.
    rst_n = 1'b0;
    @(negedge clk);
    check_out(1'b0, 1'b0, "R9 mid reset");
    rst_n = 1'b1;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule